// File: doc/BRIEF.md
# CAN Transmit Fault Monitor

This block sits beside the transmit path of a high-speed CAN transceiver and decides whether the transmitter may drive the bus. It samples the transmit data line, the received bus level, an over-temperature indication and a per-cycle bus-short comparator. From these inputs it keeps two flags. The failure flag blocks the transmitter. The bus-failure flag is only reported and never blocks anything.

The failure flag is set when a dominant request lasts too long or when the die gets too hot. It clears when the surrounding mode logic signals entry into normal mode, or when the transmit line is recessive while the bus still reads dominant. Neither path clears the flag while its cause is still present.

The bus-failure flag watches whole dominant bits. A dominant bit counts only if it is long enough. Four qualifying bits in a row that each saw a short raise the flag. Four qualifying bits in a row with no short lower it. All times are counted in clock cycles and set by parameters.

Top module: `can_tx_fault_monitor`

## Requirements
- R1: With txd low (0 = dominant) on DOM_TIMEOUT consecutive clock edges, fail_flag is 1 after that edge. After DOM_TIMEOUT-1 such edges it is still 0.
- R2: over_temp high at a clock edge makes fail_flag 1 after that edge.
- R3: tx_enable is 1 exactly when fail_flag is 0.
- R4: fail_flag clears at an edge where enter_normal is 1 or (txd is 1 and rxd is 0), but only if over_temp is 0 and no expired dominant timeout is still being held low on txd. A set condition at the same edge wins over the clear.
- R5: bus_fail_flag becomes 1 at the closing edge of a qualifying dominant bit, when that bit and the three qualifying bits before it each saw short_det high during their low phase. The closing edge is the first edge with txd back at 1.
- R6: bus_fail_flag becomes 0 at the closing edge of the fourth consecutive qualifying dominant bit with no short seen.
- R7: bus_fail_flag has no effect on tx_enable.
- R8: A dominant bit shorter than MIN_BIT clock edges does not qualify and leaves both runs and bus_fail_flag unchanged.
- R9: A shorted qualifying bit restarts the clean run, and a clean qualifying bit restarts the shorted run. Both runs saturate at four.
- R10: The dominant-timeout count restarts whenever txd is sampled high.
- R11: Synchronous active-high rst clears both flags and both runs, and leaves tx_enable at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| txd | input | 1 | Transmit data from the controller, 0 = dominant |
| rxd | input | 1 | Received bus level, 0 = dominant |
| over_temp | input | 1 | Over-temperature indication |
| short_det | input | 1 | Bus-line short comparator, sampled while txd is low |
| enter_normal | input | 1 | Mode logic is entering normal mode |
| tx_enable | output | 1 | Transmitter may drive the bus |
| fail_flag | output | 1 | Timeout or thermal failure |
| bus_fail_flag | output | 1 | Repeated bus short seen |

## Verification
The assertions assume that every input is a clean synchronous level, sampled once per edge. They also assume that short_det matters only while txd is low, and that the closing edge of a bit is the one where txd returns high. The bench changes inputs only mid-cycle and holds each bit's short_det value steady for the whole low phase. It keeps MIN_BIT well below DOM_TIMEOUT, so no sweep bit is ever long enough to trip the timeout by accident.

// File: rtl/can_tx_fault_monitor.sv
module can_tx_fault_monitor #(
  parameter int DOM_TIMEOUT = 30000,
  parameter int MIN_BIT     = 100,
  parameter int RUN         = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic txd,
  input  logic rxd,
  input  logic over_temp,
  input  logic short_det,
  input  logic enter_normal,
  output logic tx_enable,
  output logic fail_flag,
  output logic bus_fail_flag
);
  localparam int CW = $clog2(DOM_TIMEOUT + 1);
  localparam int RW = $clog2(RUN + 1);
  localparam logic [CW-1:0] TO_MAX  = CW'(DOM_TIMEOUT);
  localparam logic [CW-1:0] TO_LAST = CW'(DOM_TIMEOUT - 1);
  localparam logic [CW-1:0] BIT_MIN = CW'(MIN_BIT);
  localparam logic [RW-1:0] RUN_MAX = RW'(RUN);
  localparam logic [RW-1:0] RUN_PRE = RW'(RUN - 1);

  logic [CW-1:0] dom_cnt;
  logic [RW-1:0] sh_cnt, cl_cnt;
  logic expired, short_seen;

  wire run_end  = txd && (dom_cnt != '0);
  wire bit_ok   = run_end && (dom_cnt >= BIT_MIN);
  wire to_hit   = !txd && (dom_cnt == TO_LAST);
  wire cause    = over_temp || (expired && !txd);
  wire clr_req  = enter_normal || (txd && !rxd);
  wire fail_set = over_temp || to_hit;
  wire fail_clr = clr_req && !cause && !fail_set;

  assign tx_enable = !fail_flag;

  always_ff @(posedge clk) begin
    if (rst) begin
      dom_cnt    <= '0;
      short_seen <= 1'b0;
      expired    <= 1'b0;
      fail_flag  <= 1'b0;
    end else begin
      if (txd)                  dom_cnt <= '0;
      else if (dom_cnt != TO_MAX) dom_cnt <= dom_cnt + 1'b1;
      short_seen <= txd ? 1'b0 : (short_seen | short_det);
      if (fail_set)      fail_flag <= 1'b1;
      else if (fail_clr) fail_flag <= 1'b0;
      if (to_hit)        expired <= 1'b1;
      else if (fail_clr) expired <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_cnt        <= '0;
      cl_cnt        <= '0;
      bus_fail_flag <= 1'b0;
    end else if (bit_ok) begin
      if (short_seen) begin
        cl_cnt <= '0;
        if (sh_cnt != RUN_MAX) sh_cnt <= sh_cnt + 1'b1;
        if (sh_cnt >= RUN_PRE) bus_fail_flag <= 1'b1;
      end else begin
        sh_cnt <= '0;
        if (cl_cnt != RUN_MAX) cl_cnt <= cl_cnt + 1'b1;
        if (cl_cnt >= RUN_PRE) bus_fail_flag <= 1'b0;
      end
    end
  end

  p_thermal_r2: assert property (@(posedge clk) disable iff (rst)
    over_temp |=> fail_flag);
  p_fail_cause_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(fail_flag) |-> ($past(over_temp) || !$past(txd)));
  p_fail_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (fail_flag && !enter_normal && !(txd && !rxd)) |=> fail_flag);
  p_txen_back_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_enable) |-> ($past(enter_normal) || ($past(txd) && !$past(rxd))));
  p_bus_at_close_r5: assert property (@(posedge clk) disable iff (rst)
    $changed(bus_fail_flag) |-> ($past(txd) && !$past(txd, 2)));
  p_runs_r9: assert property (@(posedge clk) disable iff (rst)
    (sh_cnt <= RUN_MAX) && (cl_cnt <= RUN_MAX) && !((sh_cnt != '0) && (cl_cnt != '0)));
  p_short_bit_r8: assert property (@(posedge clk) disable iff (rst)
    (run_end && !bit_ok) |=> $stable(bus_fail_flag));
endmodule

// File: tb/tb_can_tx_fault_monitor.sv
module tb_can_tx_fault_monitor;
  localparam int TO = 16, MB = 3, RN = 4;
  logic clk = 0, rst = 1, txd = 1, rxd = 1, over_temp = 0, short_det = 0, enter_normal = 0;
  logic tx_enable, fail_flag, bus_fail_flag;
  int checks = 0, errors = 0;
  int m_sh = 0, m_cl = 0;
  logic m_bus = 0;

  can_tx_fault_monitor #(.DOM_TIMEOUT(TO), .MIN_BIT(MB), .RUN(RN)) dut (
    .clk(clk), .rst(rst), .txd(txd), .rxd(rxd), .over_temp(over_temp),
    .short_det(short_det), .enter_normal(enter_normal),
    .tx_enable(tx_enable), .fail_flag(fail_flag), .bus_fail_flag(bus_fail_flag));

  always #10 clk = ~clk;

  task automatic tick(); @(posedge clk); #5; endtask

  task automatic chk(string rq, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %b expected %b", rq, act, exp);
    end
  endtask

  task automatic mdl_bit(int len, logic sh);
    if (len >= MB) begin
      if (sh) begin m_cl = 0; if (m_sh < RN) m_sh++; if (m_sh == RN) m_bus = 1; end
      else    begin m_sh = 0; if (m_cl < RN) m_cl++; if (m_cl == RN) m_bus = 0; end
    end
  endtask

  task automatic send_bit(int len, logic sh);
    txd = 0; short_det = sh;
    for (int i = 0; i < len; i++) tick();
    txd = 1; short_det = 0;
    tick();
    mdl_bit(len, sh);
  endtask

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(); tick(); rst = 0; tick();
    chk("R11 fail", fail_flag, 0);
    chk("R11 bus", bus_fail_flag, 0);
    chk("R11 txen", tx_enable, 1);

    for (int n = 1; n <= TO + 2; n++) begin
      txd = 0;
      for (int i = 0; i < n; i++) tick();
      chk("R1 timeout", fail_flag, n >= TO);
      chk("R3 txen", tx_enable, n < TO);
      txd = 1; rxd = 0; tick(); rxd = 1;
      mdl_bit(n, 0);
      chk("R4 clear rxd low", fail_flag, 0);
      chk("R7 bus", bus_fail_flag, m_bus);
    end

    txd = 0; for (int i = 0; i < TO - 1; i++) tick();
    txd = 1; tick(); mdl_bit(TO - 1, 0);
    txd = 0; for (int i = 0; i < TO - 1; i++) tick();
    chk("R10 restart", fail_flag, 0);
    txd = 1; tick(); mdl_bit(TO - 1, 0);

    txd = 0; for (int i = 0; i < TO + 1; i++) tick();
    chk("R1 set", fail_flag, 1);
    enter_normal = 1; tick(); enter_normal = 0;
    chk("R4 cause held", fail_flag, 1);
    txd = 1; tick(); mdl_bit(TO + 2, 0);
    chk("R4 no clear request", fail_flag, 1);
    enter_normal = 1; tick(); enter_normal = 0;
    chk("R4 normal entry", fail_flag, 0);
    chk("R3 txen back", tx_enable, 1);

    over_temp = 1; tick();
    chk("R2 thermal", fail_flag, 1);
    chk("R3 txen off", tx_enable, 0);
    enter_normal = 1; tick();
    chk("R4 hot blocks clear", fail_flag, 1);
    over_temp = 0; tick(); enter_normal = 0;
    chk("R4 cool clear", fail_flag, 0);

    for (int p = 0; p < 64; p++) begin
      for (int b = 0; b < 6; b++) begin
        send_bit(MB + (b % 2), p[b]);
        chk("R5 R6 R9 bus", bus_fail_flag, m_bus);
        chk("R7 txen", tx_enable, 1);
        if (b == p % 6) begin
          send_bit(MB - 1, !p[b]);
          chk("R8 ignored", bus_fail_flag, m_bus);
        end
      end
    end

    for (int k = 0; k < RN; k++) send_bit(MB, 1);
    chk("R5 four shorts", bus_fail_flag, 1);
    chk("R7 still enabled", tx_enable, 1);
    for (int k = 0; k < RN - 1; k++) send_bit(MB, 0);
    chk("R6 three clean", bus_fail_flag, 1);
    send_bit(MB, 0);
    chk("R6 four clean", bus_fail_flag, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule